// File: doc/BRIEF.md
# Phase-Correct Dual-Slope PWM Timer

An 8-bit timer whose counter climbs from 0 to 255 and then falls back to 0. It drives two pulse-width-modulated outputs whose edges sit symmetrically around the bottom of the sweep. A prescaler turns the system clock into a step enable with a selectable divide ratio. Each channel compares the counter against its own compare value. That value is double-buffered and only takes effect at the top of the sweep, so a waveform never glitches in the middle of a period.

Each channel can be inverted, and its pin copy is driven only when that channel's drive enable is set. Channel A also has a toggle mode. A one-clock bottom flag marks each return to 0. A one-clock match flag per channel marks every step on which the counter lands on the compare value.

Output symmetry is kept by a rule at the top of the sweep. On arrival at 255, a channel takes the level that an upward match would have given, even if no match happened. This covers a compare value that has just moved away from 255, and a counter that was already above a newly loaded compare value.

Top module: `pcpwm_timer`

## Requirements
- R1: `rate_sel` picks the step divide ratio N: 1→1, 2→8, 3→64, 4→256, 5→1024. The values 0, 6 and 7 stop the counter. The counter advances once every N clocks, so one full sweep takes 510·N clocks. Any change of `rate_sel` restarts the divide count from zero, so the sweep in which the change happens lasts 510·N+1 clocks.
- R2: The counter runs 0,1,…,255,254,…,1,0 and holds each end value for a single step. `bottom_flag` is high for exactly one clock each time the counter arrives at 0.
- R3: Without inversion or toggle, a channel's waveform goes low when the counter arrives at the compare value while rising. It goes high when the counter arrives at it while falling.
- R4: When `invert_x` is 1, `wave_x` is the complement of the level given by R3, R5 and R6.
- R5: A compare value of 0 keeps the non-inverted waveform low all the time, because a match at 0 acts as a rising match. A compare value of 255 keeps it high all the time.
- R6: On arrival at 255 a channel not in toggle mode takes the low (rising-match) level, unless its compare value is 255, in which case it takes the high level. A compare value that moves away from 255 therefore gives a falling edge at the top with no match.
- R7: A compare value applied mid-sweep has no effect until the counter next arrives at 255. From that step on it is used.
- R8: With `toggle_a` set, channel A inverts its level on each match and ignores the top rule. Channel B has no toggle mode and follows R3 whatever `toggle_a` is.
- R9: `pin_x` equals `wave_x` when `drive_x` is 1 and is 0 when `drive_x` is 0.
- R10: `match_x` is high for one clock after each step that lands on the channel's active compare value: offsets v and 510−v of a sweep that starts at the bottom flag.
- R11: While `rate_sel` is 0 the counter, waveforms and flags hold still. Stepping resumes from the held count when a rate is selected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 3 | Prescaler select (R1 encoding) |
| cmp_val_a | input | 8 | Channel A compare value (buffered) |
| cmp_val_b | input | 8 | Channel B compare value (buffered) |
| invert_a | input | 1 | Channel A inverted output |
| invert_b | input | 1 | Channel B inverted output |
| toggle_a | input | 1 | Channel A toggle-on-match mode |
| drive_a | input | 1 | Channel A pin drive enable |
| drive_b | input | 1 | Channel B pin drive enable |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| pin_a | output | 1 | Channel A gated pin value |
| pin_b | output | 1 | Channel B gated pin value |
| bottom_flag | output | 1 | One-clock pulse on arrival at 0 |
| match_a | output | 1 | One-clock pulse on channel A match |
| match_b | output | 1 | One-clock pulse on channel B match |

## Verification
The bench drives compare values of 0 and 255. A design that treats 0 as a falling match would leave a one-step spike at the bottom, and one that forces the top level blindly would pull a 255 duty cycle low. It moves the compare value from 255 to 100 in mid-sweep: missing the forced top edge would hold the wave high for a whole extra half period, and missing the buffering would cut the edge early at offset 100. It also times sweeps across changes of rate select and across a stop. A prescaler that does not restart, or a stop that loses the count, moves the next bottom flag away from the exact clock that is expected.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

  localparam int PRE_MAX = 1024;
  localparam int PRE_W   = $clog2(PRE_MAX) + 1;

  // Divide ratio for a rate select code; zero means stopped.
  function automatic logic [PRE_W-1:0] presc_div(input logic [2:0] code);
    case (code)
      3'd1:    return PRE_W'(1);
      3'd2:    return PRE_W'(8);
      3'd3:    return PRE_W'(64);
      3'd4:    return PRE_W'(256);
      3'd5:    return PRE_W'(1024);
      default: return PRE_W'(0);
    endcase
  endfunction

  // Next non-inverted level of a channel on a counter step.
  function automatic logic next_level(input logic cur, input logic hit,
                                      input logic rising, input logic at_top,
                                      input logic at_bot, input logic cmp_is_top,
                                      input logic tog);
    if (tog)            return hit ? ~cur : cur;
    else if (at_top)    return cmp_is_top;
    else if (hit)       return (rising || at_bot) ? 1'b0 : 1'b1;
    else                return cur;
  endfunction

endpackage

// File: rtl/pcpwm_prescaler.sv
module pcpwm_prescaler
  import pcpwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);

  logic [2:0]       sel_q;
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] div;
  logic             restart;

  assign div     = presc_div(sel);
  assign restart = (sel != sel_q);
  assign tick    = (div != '0) && !restart && (pcnt == div - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      pcnt  <= '0;
    end else begin
      sel_q <= sel;
      if (restart || div == '0 || tick) pcnt <= '0;
      else                              pcnt <= pcnt + 1'b1;
    end
  end

  // R1: a stopped select never yields a step
  assert_stop_no_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0) |-> !tick);

endmodule

// File: rtl/pcpwm_counter.sv
module pcpwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] arr_val,
  output logic         arr_up,
  output logic         arr_top,
  output logic         arr_bot,
  output logic         bot_flag
);

  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cnt;
  logic         up;

  always_comb begin
    arr_up  = up;
    arr_val = up ? cnt + 1'b1 : cnt - 1'b1;
    arr_top = (arr_val == MAXV);
    arr_bot = (arr_val == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      up       <= 1'b1;
      bot_flag <= 1'b0;
    end else begin
      bot_flag <= tick && arr_bot;
      if (tick) begin
        cnt <= arr_val;
        if (arr_top)      up <= 1'b0;
        else if (arr_bot) up <= 1'b1;
      end
    end
  end

  // R2: top value held for one step, then descend
  assert_turn_at_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == MAXV) |=> (cnt == MAXV - 1'b1));

  // R2: bottom flag only while the count sits at zero
  assert_flag_at_bottom_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bot_flag |-> (cnt == '0));

endmodule

// File: rtl/pcpwm_channel.sv
module pcpwm_channel
  import pcpwm_pkg::*;
#(
  parameter int W      = 8,
  parameter bit TOG_OK = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] arr_val,
  input  logic         arr_up,
  input  logic         arr_top,
  input  logic         arr_bot,
  input  logic [W-1:0] cmp_in,
  input  logic         inv,
  input  logic         tog_req,
  input  logic         drv,
  output logic         wave,
  output logic         pin,
  output logic         match
);

  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cmp_act;
  logic [W-1:0] cmp_eff;
  logic         hit;
  logic         tog_mode;
  logic         level;
  logic         level_nxt;

  assign tog_mode  = tog_req & TOG_OK;
  assign cmp_eff   = arr_top ? cmp_in : cmp_act;
  assign hit       = (arr_val == cmp_eff);
  assign level_nxt = next_level(level, hit, arr_up, arr_top, arr_bot,
                                (cmp_in == MAXV), tog_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_act <= '0;
      level   <= 1'b0;
      match   <= 1'b0;
    end else begin
      match <= tick && hit;
      if (tick) begin
        level <= level_nxt;
        if (arr_top) cmp_act <= cmp_in;
      end
    end
  end

  assign wave = level ^ inv;
  assign pin  = drv & wave;

  // R11: no step, no change of level
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(level));

  // R5: zero compare keeps the level low at the bottom
  assert_bottom_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && arr_bot && cmp_act == '0 && !tog_mode) |=> (level == 1'b0));

  // R6: top arrival sets the rising-match level unless compare is top
  assert_top_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && arr_top && !tog_mode) |=> (level == $past(cmp_in == MAXV)));

  // R10: match flag lasts a single clock
  assert_match_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> !match);

endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   rate_sel,
  input  logic [W-1:0] cmp_val_a,
  input  logic [W-1:0] cmp_val_b,
  input  logic         invert_a,
  input  logic         invert_b,
  input  logic         toggle_a,
  input  logic         drive_a,
  input  logic         drive_b,
  output logic         wave_a,
  output logic         wave_b,
  output logic         pin_a,
  output logic         pin_b,
  output logic         bottom_flag,
  output logic         match_a,
  output logic         match_b
);

  localparam int NCH = 2;

  logic         step_en;
  logic [W-1:0] arr_val;
  logic         arr_up;
  logic         arr_top;
  logic         arr_bot;

  logic [NCH-1:0][W-1:0] cmp_v;
  logic [NCH-1:0]        inv_v;
  logic [NCH-1:0]        tog_v;
  logic [NCH-1:0]        drv_v;
  logic [NCH-1:0]        wave_v;
  logic [NCH-1:0]        pin_v;
  logic [NCH-1:0]        match_v;

  assign cmp_v = {cmp_val_b, cmp_val_a};
  assign inv_v = {invert_b, invert_a};
  assign tog_v = {1'b0, toggle_a};
  assign drv_v = {drive_b, drive_a};

  pcpwm_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (rate_sel),
    .tick (step_en)
  );

  pcpwm_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (step_en),
    .arr_val (arr_val),
    .arr_up  (arr_up),
    .arr_top (arr_top),
    .arr_bot (arr_bot),
    .bot_flag(bottom_flag)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pcpwm_channel #(.W(W), .TOG_OK(i == 0)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (step_en),
      .arr_val(arr_val),
      .arr_up (arr_up),
      .arr_top(arr_top),
      .arr_bot(arr_bot),
      .cmp_in (cmp_v[i]),
      .inv    (inv_v[i]),
      .tog_req(tog_v[i]),
      .drv    (drv_v[i]),
      .wave   (wave_v[i]),
      .pin    (pin_v[i]),
      .match  (match_v[i])
    );
  end

  assign wave_a  = wave_v[0];
  assign wave_b  = wave_v[1];
  assign pin_a   = pin_v[0];
  assign pin_b   = pin_v[1];
  assign match_a = match_v[0];
  assign match_b = match_v[1];

endmodule

// File: tb/test_pcpwm_timer.sv
module test_pcpwm_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic [7:0] cmp_val_a = 8'd0, cmp_val_b = 8'd0;
  logic       invert_a = 0, invert_b = 0, toggle_a = 0, drive_a = 0, drive_b = 0;
  logic       wave_a, wave_b, pin_a, pin_b, bottom_flag, match_a, match_b;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pcpwm_timer i_pcpwm_timer (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
    .cmp_val_a(cmp_val_a), .cmp_val_b(cmp_val_b),
    .invert_a(invert_a), .invert_b(invert_b), .toggle_a(toggle_a),
    .drive_a(drive_a), .drive_b(drive_b),
    .wave_a(wave_a), .wave_b(wave_b), .pin_a(pin_a), .pin_b(pin_b),
    .bottom_flag(bottom_flag), .match_a(match_a), .match_b(match_b)
  );

  typedef struct {
    int    off;
    bit    rel;
    bit    full;
    logic  a;
    logic  b;
    logic  pa;
    logic  ca;
    string tag;
  } item_t;

  item_t q[$];
  bit    synced = 0;
  int    since = 0;
  logic  base_a = 0;

  task automatic chk(string req, int act, int exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected non-inverted level at sweep offset (0 = bottom flag cycle)
  function automatic logic ref_level(int off, int v);
    if (v == 0)   return 1'b0;
    if (v == 255) return 1'b1;
    if (off == 0) return 1'b1;
    if (off <= 255) return (off < v);
    return ((510 - off) <= v);
  endfunction

  function automatic logic ref_match(int off, int v);
    return (off == v) || (off == 510 - v);
  endfunction

  // Monitor: syncs on the bottom flag and compares queued items
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      if (!synced) begin
        if (bottom_flag) begin synced = 1; since = 0; end
      end else since++;
      if (synced && q[0].off == since) begin
        item_t it;
        logic ea;
        it = q.pop_front();
        if (it.rel && it.off == 0) base_a = wave_a;
        ea = it.rel ? (base_a ^ it.a) : it.a;
        chk(it.tag, wave_a, ea, $sformatf("wave_a @%0d", it.off));
        if (it.full) begin
          chk(it.tag, wave_b, it.b, $sformatf("wave_b @%0d", it.off));
          chk("R9", pin_a, it.pa, $sformatf("pin_a @%0d", it.off));
          chk("R10", match_a, it.ca, $sformatf("match_a @%0d", it.off));
        end
        if (q.size() == 0) synced = 0;
      end
    end
  end

  task automatic wait_bottom();
    @(negedge clk);
    while (!bottom_flag) @(negedge clk);
  endtask

  // Driver: apply a setting, let it load at the top, queue one full sweep
  task automatic sweep(int va, int vb, bit ia, bit ib, bit da, bit tg, string tag);
    cmp_val_a = 8'(va); cmp_val_b = 8'(vb);
    invert_a = ia; invert_b = ib; drive_a = da; toggle_a = tg;
    wait_bottom();
    wait_bottom();
    #1;
    for (int k = 0; k < 510; k++) begin
      item_t it;
      logic la;
      la = tg ? logic'(k >= va && k < 510 - va) : ref_level(k, va);
      it.off = k; it.rel = tg; it.full = 1;
      it.a = tg ? la : (la ^ ia);
      it.b = ref_level(k, vb) ^ ib;
      it.pa = tg ? 1'bx : (da ? (la ^ ia) : 1'b0);
      it.ca = ref_match(k, va);
      it.tag = tag;
      if (tg) it.pa = 1'b0;
      q.push_back(it);
    end
    if (tg) drive_a = 0;
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic push_a(int off, logic a, string tag);
    item_t it;
    it.off = off; it.rel = 0; it.full = 0; it.a = a;
    it.b = 0; it.pa = 0; it.ca = 0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic period_after_change(logic [2:0] s, int exp, string tag);
    int n;
    rate_sel = s;
    n = 0;
    do begin @(negedge clk); n++; end while (!bottom_flag);
    chk(tag, n, exp, $sformatf("clocks to bottom, select %0d", s));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk("R2", bottom_flag, 0, "bottom_flag in reset");
    chk("R3", wave_a, 0, "wave_a in reset");
    chk("R10", match_a, 0, "match_a in reset");
    rst_n = 1;
    @(negedge clk);
    chk("R9", pin_a, 0, "pin_a after reset");
    rate_sel = 3'd1;

    // R3 R10: plain non-inverted channels
    sweep(100, 30, 0, 0, 1, 0, "R3");
    // R4 R5 R9: A inverted with drive off, B at zero compare
    sweep(200, 0, 1, 0, 0, 0, "R4");
    // R5 R4: both at 255, B inverted
    sweep(255, 255, 0, 1, 1, 0, "R5");
    // R8: toggle on channel A, B unaffected
    sweep(60, 150, 0, 0, 0, 1, "R8");

    // R6 R7: compare leaves 255 in mid-sweep
    toggle_a = 0; invert_a = 0; cmp_val_a = 8'd255;
    wait_bottom(); wait_bottom();
    #1;
    push_a(150, 1'b1, "R7");
    push_a(254, 1'b1, "R7");
    push_a(255, 1'b0, "R6");
    push_a(409, 1'b0, "R6");
    push_a(410, 1'b1, "R3");
    wait (synced);
    repeat (10) @(negedge clk);
    cmp_val_a = 8'd100;
    while (q.size() > 0) @(negedge clk);

    // R1 R2: sweep lengths across select changes
    wait_bottom();
    @(negedge clk);
    chk("R2", bottom_flag, 0, "bottom_flag width");
    wait_bottom();
    period_after_change(3'd2, 4081, "R1");
    period_after_change(3'd3, 32641, "R1");
    period_after_change(3'd1, 511, "R1");
    begin
      int n;
      n = 0;
      do begin @(negedge clk); n++; end while (!bottom_flag);
      chk("R2", n, 510, "steady sweep length");
    end

    // R11: stop, hold, resume
    repeat (20) @(negedge clk);
    rate_sel = 3'd0;
    begin
      logic wa0;
      int   seen;
      @(negedge clk);
      wa0 = wave_a;
      seen = 0;
      repeat (1500) begin
        @(negedge clk);
        if (bottom_flag || match_a || wave_a !== wa0) seen++;
      end
      chk("R11", seen, 0, "activity while stopped");
    end
    period_after_change(3'd1, 491, "R11");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule